// File: doc/BRIEF.md
# Shared Interrupt Source Bank

This block gathers a bank of external interrupt lines (32 by default) that are shared across processors. Every line passes through a two-flop synchroniser and is then qualified by three configuration bits of its own: a trigger-type bit picks level or edge detection, a polarity bit picks the active level or the active edge, and a dual bit makes an edge source respond to both transitions. Each line holds a pending bit. A level source's pending bit follows its qualified input. An edge source's pending bit latches and stays set until software clears it.

Software reaches the bank through a 32-bit register port with a write strobe and a combinational read path. Masks are changed only through separate write-one-to-set and write-one-to-clear addresses. A software-trigger address raises or drops the pending bit of one edge source, chosen by number. Each line also has a routing word that names a processor pin and carries a flag asking for NMI delivery. The block presents two things to the interrupt fabric: the masked pending vector and the routing words. The fabric does all arbitration and delivery.

Top module: `irq_src_bank`

## Requirements
- R1: After reset, the polarity, trigger, dual and mask bits are all 0, every routing word reads 0, and `irq_out` is 0.
- R2: A change on `irq_in[i]` that is sampled at rising edge k shows in the pending bit of line i (and in `irq_out`) right after rising edge k+2, and not before.
- R3: With trigger bit 0 (level), the pending bit equals the synchronised input when polarity is 1, and its inverse when polarity is 0. It follows the input in both directions, and the dual bit has no effect.
- R4: With trigger bit 1 and dual bit 0, a rising edge sets pending when polarity is 1 and a falling edge sets it when polarity is 0. The opposite edge is ignored. Pending then stays set with the input idle.
- R5: With trigger bit 1 and dual bit 1, both edges set pending, whatever the polarity bit holds.
- R6: A write to 0x280 picks line number `wdata[7:0]`. With `wdata[31]`=1 it sets that line's pending bit, and with `wdata[31]`=0 it clears it. It has no effect on a level line or on a number at or above the line count. A hardware edge in the same cycle as a clear wins.
- R7: A write to 0x380 sets each mask bit whose data bit is 1. A write to 0x300 clears each mask bit whose data bit is 1. Zero data bits leave the mask alone. The mask is read at 0x400.
- R8: `irq_out[i]` is 1 exactly when pending bit i and mask bit i are both 1. A masked line keeps its pending bit, which reads at 0x480.
- R9: The polarity, trigger and dual bits of line i are bit i%32 of the word at 0x100, 0x180 and 0x200 plus 4*(i/32). These read back as written. Writes to 0x400 and 0x480 change nothing. The addresses 0x280, 0x300 and 0x380, and any undecoded address, read 0.
- R10: The routing word of line n sits at 0x500+4n. Bit 31 is the pin-route flag, bit 30 is the NMI flag, bits 5:0 are the pin number, and all other bits read 0. The word also appears on `irq_route[32n+31:32n]` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Raw asynchronous interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | NUM_IRQ | Pending AND mask, one bit per line |
| irq_route | output | NUM_IRQ*32 | Routing word of each line, line n at bits 32n+31:32n |

## Verification
The bench checks when a level source drops its pending bit and when an edge source keeps it. A design that latched level inputs would hold `irq_out` after the input went away. One that ignored polarity on edges would fire on the wrong transition. It also drives the software trigger at a level line and at an out-of-range number. An implementation that skipped the trigger-type check would raise a level line that has no active input. A design that decoded only some number bits would alias onto a real line. Mask writes with mixed zero and one bits catch a design that copies the data word instead of setting or clearing. Random traffic, compared against a queue-based model on every cycle, catches the cycle where a hardware edge and a software clear meet. It also catches an extra or missing synchroniser stage.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   localparam int REG_W       = 32;
   localparam int PIN_W       = 6;
   localparam int SW_NUM_W    = 8;
   localparam int SW_SET_BIT  = 31;
   localparam int MAP_PIN_BIT = 31;
   localparam int MAP_NMI_BIT = 30;

   // register offsets; the bank fabric decodes these
   localparam int OFS_POL    = 'h100;
   localparam int OFS_TRIG   = 'h180;
   localparam int OFS_DUAL   = 'h200;
   localparam int OFS_SWTRIG = 'h280;
   localparam int OFS_MCLR   = 'h300;
   localparam int OFS_MSET   = 'h380;
   localparam int OFS_MASK   = 'h400;
   localparam int OFS_PEND   = 'h480;
   localparam int OFS_MAP    = 'h500;

   typedef struct packed {
      logic             to_pin;
      logic             to_nmi;
      logic [PIN_W-1:0] pin;
   } route_t;

   function automatic logic [REG_W-1:0] route_word(input route_t r);
      logic [REG_W-1:0] w;
      w                   = '0;
      w[MAP_PIN_BIT]      = r.to_pin;
      w[MAP_NMI_BIT]      = r.to_nmi;
      w[PIN_W-1:0]        = r.pin;
      return w;
   endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("irq_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= 1'b0;
            else        ff_q <= d_i;
         end
         assign q_o = ff_q;
      end else begin : g_chain
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else        sr_q <= {sr_q[STAGES-2:0], d_i};
         end
         assign q_o = sr_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic pol_i,
   input  logic trig_i,
   input  logic dual_i,
   input  logic sw_set_i,
   input  logic sw_clr_i,
   output logic pend_o
);

   logic sync_s;
   logic prev_q;
   logic pend_q;
   logic rise_s;
   logic fall_s;
   logic hit_s;
   logic active_s;

   irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_i),
      .q_o   (sync_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_s;
   end

   assign rise_s   = sync_s & ~prev_q;
   assign fall_s   = ~sync_s & prev_q;
   assign hit_s    = dual_i ? (rise_s | fall_s) : (pol_i ? rise_s : fall_s);
   assign active_s = pol_i ? sync_s : ~sync_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (!trig_i) begin
         pend_q <= active_s;
      end else if (hit_s || sw_set_i) begin
         pend_q <= 1'b1;
      end else if (sw_clr_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i && pend_q && !sw_clr_i |=> pend_q); // R4

   AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      trig_i && sw_clr_i && !hit_s |=> !pend_q); // R6

   AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_i |=> pend_q == $past(sync_s == pol_i)); // R3

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
   import irq_bank_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int ADDR_W  = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [REG_W-1:0]          wdata_i,
   output logic [REG_W-1:0]          rdata_o,
   input  logic [NUM_IRQ-1:0]        pend_i,
   output logic [NUM_IRQ-1:0]        pol_o,
   output logic [NUM_IRQ-1:0]        trig_o,
   output logic [NUM_IRQ-1:0]        dual_o,
   output logic [NUM_IRQ-1:0]        mask_o,
   output logic [NUM_IRQ-1:0]        sw_set_o,
   output logic [NUM_IRQ-1:0]        sw_clr_o,
   output route_t [NUM_IRQ-1:0]      route_o
);

   logic [NUM_IRQ-1:0]   pol_q;
   logic [NUM_IRQ-1:0]   trig_q;
   logic [NUM_IRQ-1:0]   dual_q;
   logic [NUM_IRQ-1:0]   mask_q;
   route_t [NUM_IRQ-1:0] route_q;
   logic                 sw_fire;
   logic [SW_NUM_W-1:0]  sw_num;

   function automatic logic [ADDR_W-1:0] bit_word(input int base, input int idx);
      return ADDR_W'(base + 4 * (idx / REG_W));
   endfunction

   function automatic logic [ADDR_W-1:0] map_word(input int idx);
      return ADDR_W'(OFS_MAP + 4 * idx);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q   <= '0;
         trig_q  <= '0;
         dual_q  <= '0;
         mask_q  <= '0;
         route_q <= '0;
      end else if (we_i) begin
         for (int i = 0; i < NUM_IRQ; i++) begin
            if (addr_i == bit_word(OFS_POL, i))  pol_q[i]  <= wdata_i[i % REG_W];
            if (addr_i == bit_word(OFS_TRIG, i)) trig_q[i] <= wdata_i[i % REG_W];
            if (addr_i == bit_word(OFS_DUAL, i)) dual_q[i] <= wdata_i[i % REG_W];
            if (addr_i == bit_word(OFS_MSET, i) && wdata_i[i % REG_W]) mask_q[i] <= 1'b1;
            if (addr_i == bit_word(OFS_MCLR, i) && wdata_i[i % REG_W]) mask_q[i] <= 1'b0;
            if (addr_i == map_word(i)) begin
               route_q[i].to_pin <= wdata_i[MAP_PIN_BIT];
               route_q[i].to_nmi <= wdata_i[MAP_NMI_BIT];
               route_q[i].pin    <= wdata_i[PIN_W-1:0];
            end
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (addr_i == bit_word(OFS_POL, i))  rdata_o[i % REG_W] = pol_q[i];
         if (addr_i == bit_word(OFS_TRIG, i)) rdata_o[i % REG_W] = trig_q[i];
         if (addr_i == bit_word(OFS_DUAL, i)) rdata_o[i % REG_W] = dual_q[i];
         if (addr_i == bit_word(OFS_MASK, i)) rdata_o[i % REG_W] = mask_q[i];
         if (addr_i == bit_word(OFS_PEND, i)) rdata_o[i % REG_W] = pend_i[i];
         if (addr_i == map_word(i))           rdata_o            = route_word(route_q[i]);
      end
   end

   assign sw_fire = we_i && (addr_i == ADDR_W'(OFS_SWTRIG));
   assign sw_num  = wdata_i[SW_NUM_W-1:0];

   genvar g;
   generate
      for (g = 0; g < NUM_IRQ; g++) begin : g_line
         assign sw_set_o[g] = sw_fire &&  wdata_i[SW_SET_BIT] && (sw_num == SW_NUM_W'(g));
         assign sw_clr_o[g] = sw_fire && !wdata_i[SW_SET_BIT] && (sw_num == SW_NUM_W'(g));

         AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
            we_i && addr_i == bit_word(OFS_MSET, g) && wdata_i[g % REG_W] |=> mask_q[g]); // R7

         AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            we_i && addr_i == bit_word(OFS_MCLR, g) && wdata_i[g % REG_W] |=> !mask_q[g]); // R7

         AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (addr_i == bit_word(OFS_MSET, g) || addr_i == bit_word(OFS_MCLR, g)))
            |=> $stable(mask_q[g])); // R7
      end
   endgenerate

   assign pol_o   = pol_q;
   assign trig_o  = trig_q;
   assign dual_o  = dual_q;
   assign mask_o  = mask_q;
   assign route_o = route_q;

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_bank_pkg::*;
#(
   parameter int NUM_IRQ     = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IRQ-1:0]       irq_in,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [REG_W-1:0]         bus_wdata,
   output logic [REG_W-1:0]         bus_rdata,
   output logic [NUM_IRQ-1:0]       irq_out,
   output logic [NUM_IRQ*REG_W-1:0] irq_route
);

   localparam int MAX_IRQ  = 1 << SW_NUM_W;
   localparam int MAP_END  = OFS_MAP + 4 * NUM_IRQ;

   logic [NUM_IRQ-1:0]   pol_s;
   logic [NUM_IRQ-1:0]   trig_s;
   logic [NUM_IRQ-1:0]   dual_s;
   logic [NUM_IRQ-1:0]   mask_s;
   logic [NUM_IRQ-1:0]   sw_set_s;
   logic [NUM_IRQ-1:0]   sw_clr_s;
   logic [NUM_IRQ-1:0]   pend_s;
   route_t [NUM_IRQ-1:0] route_s;

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > MAX_IRQ) begin : g_bad_num
         $error("irq_src_bank: NUM_IRQ out of range for the trigger number field");
      end
      if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
         $error("irq_src_bank: ADDR_W too small for the routing words");
      end
   endgenerate

   irq_bank_regs #(
      .NUM_IRQ (NUM_IRQ),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (bus_we),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .rdata_o  (bus_rdata),
      .pend_i   (pend_s),
      .pol_o    (pol_s),
      .trig_o   (trig_s),
      .dual_o   (dual_s),
      .mask_o   (mask_s),
      .sw_set_o (sw_set_s),
      .sw_clr_o (sw_clr_s),
      .route_o  (route_s)
   );

   genvar g;
   generate
      for (g = 0; g < NUM_IRQ; g++) begin : g_src
         irq_src_cell #(
            .SYNC_STAGES (SYNC_STAGES)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (irq_in[g]),
            .pol_i    (pol_s[g]),
            .trig_i   (trig_s[g]),
            .dual_i   (dual_s[g]),
            .sw_set_i (sw_set_s[g]),
            .sw_clr_i (sw_clr_s[g]),
            .pend_o   (pend_s[g])
         );
         assign irq_route[g*REG_W +: REG_W] = route_word(route_s[g]);
      end
   endgenerate

   assign irq_out = pend_s & mask_s;

   AST_OUT_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == ADDR_W'(OFS_MCLR) && (bus_wdata[0] == 1'b1) |=> !irq_out[0]); // R8

endmodule

// File: tb/irq_src_bank_tb.sv
module irq_src_bank_tb;

   localparam int N = 32;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [N-1:0]    irq_in;
   logic            bus_we;
   logic [11:0]     bus_addr;
   logic [31:0]     bus_wdata;
   logic [31:0]     bus_rdata;
   logic [N-1:0]    irq_out;
   logic [N*32-1:0] irq_route;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   irq_src_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out),
      .irq_route (irq_route)
   );

   // ---------------- behavioural reference model ----------------
   logic [N-1:0] m_pol, m_trig, m_dual, m_mask, m_pend;
   logic [31:0]  m_map [N];
   logic [N-1:0] hist [$];

   always @(posedge clk) begin : mdl
      logic [N-1:0] cur;
      logic [N-1:0] old;
      logic         hit;
      logic         sws;
      logic         swc;
      if (!rst_n) begin
         m_pol = '0; m_trig = '0; m_dual = '0; m_mask = '0; m_pend = '0;
         for (int i = 0; i < N; i++) m_map[i] = '0;
         hist = {};
         repeat (4) hist.push_front('0);
      end else begin
         hist.push_front(irq_in);
         cur = hist[2];
         old = hist[3];
         void'(hist.pop_back());
         for (int i = 0; i < N; i++) begin
            sws = bus_we && bus_addr == 12'h280 && bus_wdata[31]  && bus_wdata[7:0] == 8'(i);
            swc = bus_we && bus_addr == 12'h280 && !bus_wdata[31] && bus_wdata[7:0] == 8'(i);
            if (!m_trig[i]) begin
               m_pend[i] = m_pol[i] ? cur[i] : !cur[i];
            end else begin
               if (m_dual[i])     hit = cur[i] != old[i];
               else if (m_pol[i]) hit = cur[i] && !old[i];
               else               hit = !cur[i] && old[i];
               if (hit || sws)    m_pend[i] = 1'b1;
               else if (swc)      m_pend[i] = 1'b0;
            end
         end
         if (bus_we) begin
            case (bus_addr)
               12'h100: m_pol  = bus_wdata;
               12'h180: m_trig = bus_wdata;
               12'h200: m_dual = bus_wdata;
               12'h300: m_mask = m_mask & ~bus_wdata;
               12'h380: m_mask = m_mask | bus_wdata;
               default: ;
            endcase
            if (bus_addr >= 12'h500 && bus_addr < 12'h580 && bus_addr[1:0] == 2'b00)
               m_map[(bus_addr - 12'h500) >> 2] = bus_wdata & 32'hC000_003F;
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [11:0] a);
      case (a)
         12'h100: return m_pol;
         12'h180: return m_trig;
         12'h200: return m_dual;
         12'h400: return m_mask;
         12'h480: return m_pend;
         default: ;
      endcase
      if (a >= 12'h500 && a < 12'h580 && a[1:0] == 2'b00) return m_map[(a - 12'h500) >> 2];
      return '0;
   endfunction

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // every cycle: masked pending (R8) and routing outputs (R10)
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         logic [N*32-1:0] exp_route;
         chk("R8 irq_out vs model", irq_out, m_pend & m_mask);
         for (int i = 0; i < N; i++) exp_route[i*32 +: 32] = m_map[i];
         checks++;
         if (irq_route !== exp_route) begin
            errors++;
            $display("FAIL R10 irq_route actual %h expected %h", irq_route, exp_route);
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rdexp(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
      chk(req, bus_rdata, m_read(a));
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive(input logic [N-1:0] v);
      @(negedge clk);
      irq_in = v;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired, run hung");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq_in = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      chk("R1 irq_out", irq_out, 32'h0);
      rdexp("R1 mask", 12'h400, 32'h0);
      rdexp("R1 pol", 12'h100, 32'h0);
      rdexp("R1 trig", 12'h180, 32'h0);
      rdexp("R1 route", 12'h514, 32'h0);

      // R9 layout, read-only and undecoded addresses
      wr(12'h100, 32'hA5A5_0F0F); rdexp("R9 pol readback", 12'h100, 32'hA5A5_0F0F);
      wr(12'h180, 32'h1234_5678); rdexp("R9 trig readback", 12'h180, 32'h1234_5678);
      wr(12'h200, 32'h0000_FFFF); rdexp("R9 dual readback", 12'h200, 32'h0000_FFFF);
      wr(12'h400, 32'hFFFF_FFFF); rdexp("R9 mask read-only", 12'h400, 32'h0);
      rdexp("R9 undecoded", 12'h7F0, 32'h0);
      rdexp("R9 swtrig reads 0", 12'h280, 32'h0);
      rdexp("R9 mset reads 0", 12'h380, 32'h0);
      wr(12'h180, 32'h0); wr(12'h200, 32'h0); wr(12'h100, 32'hFFFF_FFFF);
      cyc(4);
      wr(12'h480, 32'hFFFF_FFFF);
      rdexp("R9 pend read-only", 12'h480, 32'h0);

      // R7 mask set / clear
      wr(12'h380, 32'h0000_00F0); rdexp("R7 set", 12'h400, 32'h0000_00F0);
      wr(12'h380, 32'h0F00_0001); rdexp("R7 set keeps", 12'h400, 32'h0F00_00F1);
      wr(12'h300, 32'h0000_0030); rdexp("R7 clear", 12'h400, 32'h0F00_00C1);
      wr(12'h300, 32'h0);         rdexp("R7 zero clear", 12'h400, 32'h0F00_00C1);
      wr(12'h380, 32'hFFFF_FFFF); rdexp("R7 set all", 12'h400, 32'hFFFF_FFFF);

      // R2 latency
      drive(32'h10);
      cyc(2); chk("R2 not yet", irq_out, 32'h0);
      cyc(1); chk("R2 arrived", irq_out, 32'h10);

      // R3 level
      drive(32'h0); cyc(4); chk("R3 follows low", irq_out, 32'h0);
      wr(12'h100, 32'hFFFF_FFEF); cyc(4); chk("R3 active low", irq_out, 32'h10);
      drive(32'h10); cyc(4); chk("R3 active low idle", irq_out, 32'h0);
      drive(32'h0); wr(12'h100, 32'hFFFF_FFFF); cyc(4);
      chk("R3 back to idle", irq_out, 32'h0);

      // R4 single edge
      wr(12'h180, 32'hFFFF_FFFF); cyc(2);
      drive(32'h1); cyc(4); chk("R4 rising sets", irq_out, 32'h1);
      drive(32'h0); cyc(4); chk("R4 sticky", irq_out, 32'h1);
      wr(12'h100, 32'hFFFF_FFFD); cyc(2);
      drive(32'h2); cyc(4); chk("R4 rise ignored on falling source", irq_out, 32'h1);
      drive(32'h0); cyc(4); chk("R4 falling sets", irq_out, 32'h3);

      // R6 software trigger
      wr(12'h280, 32'h0000_0000); chk("R6 clear line 0", irq_out, 32'h2);
      wr(12'h280, 32'h8000_0007); chk("R6 set line 7", irq_out, 32'h82);
      wr(12'h280, 32'h0000_0001); chk("R6 clear line 1", irq_out, 32'h80);
      wr(12'h280, 32'h8000_00C8); chk("R6 out of range ignored", irq_out, 32'h80);
      wr(12'h180, 32'hFFFF_FDFF); cyc(2);
      wr(12'h280, 32'h8000_0009); cyc(2); chk("R6 level line ignored", irq_out, 32'h80);

      // R5 dual edge (bit 12 edge, bit 9 level)
      wr(12'h200, 32'h0000_1200);
      wr(12'h100, 32'hFFFF_EFFD);
      drive(32'h1000); cyc(4); chk("R5 rise with pol 0", irq_out, 32'h1080);
      wr(12'h280, 32'h0000_000C); chk("R5 sw clear", irq_out, 32'h80);
      drive(32'h0); cyc(4); chk("R5 falling sets", irq_out, 32'h1080);
      drive(32'h200); cyc(4); chk("R3 dual ignored on level", irq_out, 32'h1280);
      drive(32'h0); cyc(4); chk("R3 dual level drops", irq_out, 32'h1080);

      // R10 routing
      wr(12'h514, 32'hFFFF_FFFF);
      rdexp("R10 reserved bits", 12'h514, 32'hC000_003F);
      chk("R10 route port 5", irq_route[5*32 +: 32], 32'hC000_003F);
      wr(12'h57C, 32'h4000_0015);
      rdexp("R10 nmi and pin", 12'h57C, 32'h4000_0015);
      chk("R10 route port 31", irq_route[31*32 +: 32], 32'h4000_0015);

      // R8 masked line keeps pending
      wr(12'h300, 32'h0000_0080);
      chk("R8 masked output", irq_out, 32'h1000);
      rdexp("R8 pending kept", 12'h480, 32'h1080);

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] r;
         @(negedge clk);
         bus_we = 1'b0;
         irq_in = irq_in ^ ($urandom & $urandom & $urandom);
         r = $urandom;
         case (r[2:0])
            3'd0: begin bus_we = 1'b1; bus_addr = 12'h100; bus_wdata = $urandom; end
            3'd1: begin bus_we = 1'b1; bus_addr = 12'h180; bus_wdata = $urandom; end
            3'd2: begin bus_we = 1'b1; bus_addr = 12'h200; bus_wdata = $urandom; end
            3'd3: begin bus_we = 1'b1; bus_addr = 12'h280;
                        bus_wdata = {r[8], 23'h0, 8'(r[15:10] % 40)}; end
            3'd4: begin bus_we = 1'b1; bus_addr = r[9] ? 12'h300 : 12'h380;
                        bus_wdata = $urandom; end
            3'd5: begin bus_we = 1'b1; bus_addr = 12'h500 + 12'(4 * (r[15:11] % 32));
                        bus_wdata = $urandom; end
            default: begin
               bus_addr = r[8] ? 12'h480 : 12'h400;
               #1;
               chk("R6 random readback", bus_rdata, m_read(bus_addr));
            end
         endcase
      end
      @(negedge clk);
      bus_we = 1'b0;
      cyc(4);

      summary();
      $finish;
   end

endmodule